// File: doc/BRIEF.md
# Data cache maintenance control register

This block is the software-facing control word of a data cache. Software writes one register to turn the cache on, choose the read burst style of the cache's memory-side port, drive the four event monitors, and request maintenance work. The block checks each write against the current enable and busy state. A write that asks for work at the wrong moment is dropped. A write that is accepted raises a request bit and sends a one-cycle start pulse to the maintenance engine.

There are two kinds of work: a full invalidation of the cache, and a range command whose 3-bit code selects a clean and/or invalidate operation. The engine reports progress on two busy inputs. Once the matching busy input is seen high, the block clears the request bit by itself. This keeps software from stacking a second request on an operation that is still running.

The monitor controls cover read-hit, read-miss, write-hit and write-miss counters. Each monitor has a level enable and a reset. The reset leaves the block as a single-cycle pulse and always reads back as 0. The cache array, the range walker and the counters themselves lie outside this block.

Top module: `dcm_ctrl_reg`

## Requirements
- R1: After reset every field is 0. `reg_rdata` reads 0 and no start or monitor-reset pulse is driven.
- R2: Writing 1 to bit 1 (invalidate request) is accepted only if the enable bit (bit 0) already holds 1 before the write. An accepted write sets bit 1 and drives `inv_start` high for exactly the one cycle after the write.
- R3: The invalidate request bit clears in the cycle after `inv_busy` is sampled high, unless a new accepted request arrives in that same cycle.
- R4: Writing 0 to bit 1 or to bit 5 (start command) leaves a pending request bit unchanged.
- R5: The command field (bits 4:2) takes the written value only while `cmd_busy` is 0. While `cmd_busy` is 1, a write keeps the old code.
- R6: Writing 1 to bit 5 is accepted only when all of these hold: the enable bit already holds 1, `cmd_busy` and `inv_busy` are both 0, and the code written to bits 4:2 in that same write is 1, 2 or 3. Codes 0 and 4 to 7 block the start. An accepted write sets bit 5 and drives `cmd_start` high for one cycle.
- R7: The start-command bit clears in the cycle after `cmd_busy` is sampled high.
- R8: The enable (bit 0), the read burst select (bit 6) and the monitor enables (bits 11:8, in the order read-hit, read-miss, write-hit, write-miss from bit 8 upward) take any written value. They read back and drive `cache_en`, `rd_burst_sel` and `mon_en`.
- R9: Writing 1 to a bit in 15:12 drives the matching `mon_clr` bit high for exactly the one cycle after the write. Those bits always read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Current register contents |
| inv_busy | input | 1 | Full invalidation in progress |
| cmd_busy | input | 1 | Range command in progress |
| cache_en | output | 1 | Cache enable field |
| inv_start | output | 1 | One-cycle full invalidation start |
| cmd_code | output | 3 | Range command code |
| cmd_start | output | 1 | One-cycle range command start |
| rd_burst_sel | output | 1 | Burst type for master-port reads |
| mon_en | output | NUM_MON | Monitor enables |
| mon_clr | output | NUM_MON | One-cycle monitor reset pulses |

## Verification
The request logic is tried against each blocking condition on its own: the enable bit cleared, invalidation busy, command busy, a reserved code, and a code written during a busy phase. Each of these shows which single guard term gates acceptance. Writes that set the request bits to 0 are then applied while a request is still pending, followed by idle cycles with a busy flag high. This tells a hardware clear apart from a software clear. Free-running fields and monitor reset pulses are written with mixed bit patterns, which shows whether each bit reaches its own output. It also shows that reset pulses last one cycle and do not read back.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
   // register layout; the maintenance engine decodes cmd_code directly
   localparam int unsigned BIT_EN     = 0;
   localparam int unsigned BIT_INV    = 1;
   localparam int unsigned CMD_LSB    = 2;
   localparam int unsigned CMD_W      = 3;
   localparam int unsigned BIT_GO     = 5;
   localparam int unsigned BIT_BURST  = 6;
   localparam int unsigned MON_EN_LSB = 8;

   function automatic logic code_defined(input logic [CMD_W-1:0] c);
      return (c == 3'd1) || (c == 3'd2) || (c == 3'd3);
   endfunction
endpackage

// File: rtl/dcm_req_bit.sv
module dcm_req_bit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic busy_i,
   output logic req_o,
   output logic start_o
);
   logic req_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (set_i)       req_d = 1'b1;
            else if (busy_i) req_d = 1'b0;
            else             req_d = req_o;
         end
         // R2
         start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start_o |-> req_o);
      end else begin : g_clear_first
         always_comb begin
            if (busy_i)     req_d = 1'b0;
            else if (set_i) req_d = 1'b1;
            else            req_d = req_o;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_o   <= 1'b0;
         start_o <= 1'b0;
      end else begin
         req_o   <= req_d;
         start_o <= set_i;
      end
   end

   // R3 R7
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !set_i) |=> !req_o);
endmodule

// File: rtl/dcm_cmd_reg.sv
module dcm_cmd_reg
   import dcm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CMD_W-1:0] code_i,
   input  logic             busy_i,
   output logic [CMD_W-1:0] code_o,
   output logic             code_ok_o
);
   assign code_ok_o = code_defined(code_i);

   always_ff @(posedge clk) begin
      if (!rst_n)              code_o <= '0;
      else if (wr_i && !busy_i) code_o <= code_i;
   end

   // R5
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(code_o));
endmodule

// File: rtl/dcm_mon_ctl.sv
module dcm_mon_ctl #(
   parameter int unsigned NUM_MON = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [NUM_MON-1:0] en_i,
   input  logic [NUM_MON-1:0] clr_i,
   output logic [NUM_MON-1:0] en_o,
   output logic [NUM_MON-1:0] clr_o
);
   generate
      for (genvar i = 0; i < NUM_MON; i++) begin : g_mon
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_o[i]  <= 1'b0;
               clr_o[i] <= 1'b0;
            end else begin
               if (wr_i) en_o[i] <= en_i[i];
               clr_o[i] <= wr_i & clr_i[i];
            end
         end
      end
   endgenerate

   // R9
   clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> (clr_o == '0));
endmodule

// File: rtl/dcm_ctrl_reg.sv
module dcm_ctrl_reg
   import dcm_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_MON = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               inv_busy,
   input  logic               cmd_busy,
   output logic               cache_en,
   output logic               inv_start,
   output logic [CMD_W-1:0]   cmd_code,
   output logic               cmd_start,
   output logic               rd_burst_sel,
   output logic [NUM_MON-1:0] mon_en,
   output logic [NUM_MON-1:0] mon_clr
);
   localparam int unsigned MON_CLR_LSB = MON_EN_LSB + NUM_MON;
   localparam int unsigned USED_W      = MON_CLR_LSB + NUM_MON;

   generate
      if (DATA_W < USED_W) begin : g_bad_width
         $error("DATA_W too narrow for the field layout");
      end
      if (NUM_MON == 0) begin : g_bad_mon
         $error("NUM_MON must be at least 1");
      end
   endgenerate

   logic en_q, burst_q, inv_req, go_req, code_ok;
   logic acc_inv, acc_go;

   assign acc_inv = reg_we & reg_wdata[BIT_INV] & en_q;
   assign acc_go  = reg_we & reg_wdata[BIT_GO] & en_q & ~cmd_busy
                    & ~inv_busy & code_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         burst_q <= 1'b0;
      end else if (reg_we) begin
         en_q    <= reg_wdata[BIT_EN];
         burst_q <= reg_wdata[BIT_BURST];
      end
   end

   dcm_req_bit #(.SET_WINS(1'b1)) u_inv (
      .clk(clk), .rst_n(rst_n), .set_i(acc_inv), .busy_i(inv_busy),
      .req_o(inv_req), .start_o(inv_start));

   dcm_req_bit #(.SET_WINS(1'b1)) u_go (
      .clk(clk), .rst_n(rst_n), .set_i(acc_go), .busy_i(cmd_busy),
      .req_o(go_req), .start_o(cmd_start));

   dcm_cmd_reg u_cmd (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_we),
      .code_i(reg_wdata[CMD_LSB +: CMD_W]), .busy_i(cmd_busy),
      .code_o(cmd_code), .code_ok_o(code_ok));

   dcm_mon_ctl #(.NUM_MON(NUM_MON)) u_mon (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_we),
      .en_i(reg_wdata[MON_EN_LSB +: NUM_MON]),
      .clr_i(reg_wdata[MON_CLR_LSB +: NUM_MON]),
      .en_o(mon_en), .clr_o(mon_clr));

   assign cache_en     = en_q;
   assign rd_burst_sel = burst_q;

   always_comb begin
      reg_rdata                         = '0;
      reg_rdata[BIT_EN]                 = en_q;
      reg_rdata[BIT_INV]                = inv_req;
      reg_rdata[CMD_LSB +: CMD_W]       = cmd_code;
      reg_rdata[BIT_GO]                 = go_req;
      reg_rdata[BIT_BURST]              = burst_q;
      reg_rdata[MON_EN_LSB +: NUM_MON]  = mon_en;
   end

   // R2
   inv_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_start |-> $past(cache_en));
   // R6
   go_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> $past(cache_en && !cmd_busy && !inv_busy));
   // R6
   go_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> (cmd_code == 3'd1 || cmd_code == 3'd2 || cmd_code == 3'd3));
   // R4
   inv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[BIT_INV] && !inv_busy) |=> reg_rdata[BIT_INV]);
endmodule

// File: tb/dcm_ctrl_reg_test.sv
`timescale 1ns/1ps
module dcm_ctrl_reg_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        inv_busy = 1'b0, cmd_busy = 1'b0;
   logic        cache_en, inv_start, cmd_start, rd_burst_sel;
   logic [2:0]  cmd_code;
   logic [3:0]  mon_en, mon_clr;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   dcm_ctrl_reg uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .inv_busy(inv_busy), .cmd_busy(cmd_busy),
      .cache_en(cache_en), .inv_start(inv_start), .cmd_code(cmd_code),
      .cmd_start(cmd_start), .rd_burst_sel(rd_burst_sel),
      .mon_en(mon_en), .mon_clr(mon_clr));

   typedef struct {
      logic [31:0] rd;
      logic        is, cs;
      logic [3:0]  clr;
      string       tag;
   } exp_t;

   exp_t exp_q[$];

   // requirement model
   logic       m_en = 0, m_inv = 0, m_go = 0, m_burst = 0;
   logic [2:0] m_cmd = 0;
   logic [3:0] m_mon = 0;

   function automatic logic [31:0] model_rd();
      return {16'd0, 4'd0, m_mon, 1'b0, m_burst, m_go, m_cmd, m_inv, m_en};
   endfunction

   task automatic step(input logic we, input logic [31:0] wd,
                       input logic ib, input logic cb, input string tag);
      exp_t e;
      logic a_inv, a_go;
      @(negedge clk);
      reg_we = we; reg_wdata = wd; inv_busy = ib; cmd_busy = cb;
      a_inv = we && wd[1] && m_en;
      a_go  = we && wd[5] && m_en && !cb && !ib && (wd[4:2] inside {3'd1, 3'd2, 3'd3});
      m_inv = a_inv ? 1'b1 : (ib ? 1'b0 : m_inv);
      m_go  = a_go  ? 1'b1 : (cb ? 1'b0 : m_go);
      if (we && !cb) m_cmd = wd[4:2];
      if (we) begin
         m_en = wd[0]; m_burst = wd[6]; m_mon = wd[11:8];
      end
      e.rd = model_rd(); e.is = a_inv; e.cs = a_go;
      e.clr = we ? wd[15:12] : 4'd0; e.tag = tag;
      @(posedge clk);
      exp_q.push_back(e);
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (reg_rdata !== e.rd || inv_start !== e.is || cmd_start !== e.cs ||
                mon_clr !== e.clr || cache_en !== e.rd[0] || cmd_code !== e.rd[4:2] ||
                rd_burst_sel !== e.rd[6] || mon_en !== e.rd[11:8]) begin
               fails++;
               $display("FAIL %s: rdata=%h is=%b cs=%b clr=%h expected rdata=%h is=%b cs=%b clr=%h",
                        e.tag, reg_rdata, inv_start, cmd_start, mon_clr,
                        e.rd, e.is, e.cs, e.clr);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (reg_rdata !== 0 || inv_start || cmd_start || mon_clr !== 0 || mon_en !== 0) begin
         fails++;
         $display("FAIL R1: rdata=%h pulses=%b%b clr=%h expected all 0",
                  reg_rdata, inv_start, cmd_start, mon_clr);
      end
      step(1, 32'h0000_0002, 0, 0, "R2 request with enable off");
      step(1, 32'h0000_0001, 0, 0, "R8 enable on");
      step(1, 32'h0000_0003, 0, 0, "R2 accepted invalidate");
      step(0, 32'h0, 0, 0, "R2 pulse one cycle");
      step(1, 32'h0000_0001, 0, 0, "R4 zero write keeps invalidate");
      step(0, 32'h0, 1, 0, "R3 busy clears invalidate");
      step(1, 32'h0000_0029, 0, 0, "R6 start with code 2");
      step(0, 32'h0, 0, 1, "R7 busy clears start");
      step(1, 32'h0000_000D, 0, 1, "R5 code write while busy");
      step(1, 32'h0000_0031, 0, 0, "R6 reserved code 4 blocks");
      step(1, 32'h0000_0025, 1, 0, "R6 inv busy blocks");
      step(1, 32'h0000_0004, 0, 0, "R8 enable off");
      step(1, 32'h0000_0025, 0, 0, "R6 enable previously off blocks");
      step(1, 32'h0000_0025, 0, 0, "R6 start with code 1");
      step(1, 32'h0000_0005, 0, 0, "R4 zero write keeps start");
      step(0, 32'h0, 0, 1, "R7 busy clears start again");
      step(1, 32'h0000_0A41, 0, 0, "R8 burst and monitor enables");
      step(1, 32'h0000_5A41, 0, 0, "R9 monitor reset pulse");
      step(0, 32'h0, 0, 0, "R9 pulse ends");
      step(1, 32'h0000_A501, 0, 0, "R9 R8 other pattern");
      step(1, 32'h0000_0003, 1, 0, "R3 set wins over busy");
      step(0, 32'h0, 1, 0, "R3 cleared next cycle");
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule